// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM that is 16 bits wide with 19 address bits. The host side accepts one request at a time through a valid/ready handshake. A request carries an address, write data, a two-bit lane mask and a read/write flag. The controller completes the request with a single-cycle done pulse, and for reads it returns the captured data along with that pulse.

On the memory side the block drives an active-low chip select together with an active-high chip select. It also drives two active-low lane enables, one for the low byte and one for the high byte, plus an active-low write strobe and an active-low output enable. The shared data bus is split into an output value, an output-enable for the pads and an input value.

Every access runs through four phases: select setup, strobe, hold and recovery. The length of each phase is a parameter counted in clocks, so the part's nanosecond minimums become clock counts. The recovery phase is lengthened when needed so that a whole access never falls below the cycle-time minimum.

Top module: `sram_async_ctl`

## Requirements
- R1: During reset and after it, until a request arrives, the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, both lane enables high, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. `req_ready` stays 0 while reset is asserted and becomes 1 on the second clock edge after release.
- R2: For each access the chip is selected (`mem_cs_n`=0 and `mem_cs`=1) for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC clocks, starting on the clock edge that accepts the request. At all other times it is deselected.
- R3: Mask bit 0 drives `mem_bc_lo_n` low, which enables data bits 7:0. Mask bit 1 drives `mem_bc_hi_n` low, which enables bits 15:8. A lane enable is active only while the chip is selected, and for the same clocks.
- R4: A write holds `mem_we_n` low for exactly STROBE_CYC clocks. The strobe begins only after the chip has been selected for SETUP_CYC clocks, and `mem_oe_n` stays high for the whole write.
- R5: The data pads are driven (`mem_dq_oe`=1) only while `mem_we_n` is low. While they are driven they carry the request's write data, unchanged. The pads are never driven during a read.
- R6: A read holds `mem_oe_n` low for exactly STROBE_CYC clocks while `mem_we_n` stays high. The bus is sampled on the last strobe clock. Lanes whose mask bit is 0 read as zero.
- R7: `rsp_done` pulses high for exactly one clock, SETUP_CYC+STROBE_CYC clocks after the accepting edge. `rsp_rdata` is valid while `rsp_done` is high.
- R8: `req_ready` is low from the accepting edge until recovery ends. A full access lasts SETUP_CYC+STROBE_CYC+HOLD_CYC+R clocks, where R is the larger of RECOV_CYC and CYCLE_MIN_CYC−(SETUP_CYC+STROBE_CYC+HOLD_CYC).
- R9: `mem_addr` carries the request address and does not change while the chip is selected.
- R10: A request whose mask is 00 asserts no lane enable and leaves the memory contents unchanged. It still completes with a done pulse, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_bc_lo_n | output | 1 | Active-low low-byte enable |
| mem_bc_hi_n | output | 1 | Active-low high-byte enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DATA_W | Data to pads |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | DATA_W | Data from pads |

## Verification
All memory-side outputs are registered from the next phase. Each one therefore changes on the accepting edge or on a phase boundary, never in between. The bench counts the falling edges that follow the accepting edge, starting from k=0. At each one it records the selects, lane enables, strobe, output enable and pad enable. It expects the strobe to begin at k=SETUP_CYC, done at k=SETUP_CYC+STROBE_CYC, and ready at k equal to the full access length. Read data is compared at the falling edge where done is seen, against a bench shadow of the memory model masked lane by lane. A second instance with a long cycle minimum checks the stretched recovery.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int SETUP_LEN  = 1,
  parameter int STROBE_LEN = 5,
  parameter int HOLD_LEN   = 1,
  parameter int RECOV_LEN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last,
  output phase_e           phase,
  output phase_e           phase_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_SETUP;  load = 1'b1; load_val = CNT_W'(SETUP_LEN - 1);
      end
      PH_SETUP: if (last) begin
        phase_d = PH_STROBE; load = 1'b1; load_val = CNT_W'(STROBE_LEN - 1);
      end
      PH_STROBE: if (last) begin
        phase_d = PH_HOLD;   load = 1'b1; load_val = CNT_W'(HOLD_LEN - 1);
      end
      PH_HOLD: if (last) begin
        phase_d = PH_RECOV;  load = 1'b1; load_val = CNT_W'(RECOV_LEN - 1);
      end
      PH_RECOV: if (last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase     = phase_q;
  assign phase_nxt = phase_d;
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int SETUP_CYC     = 1,
  parameter int STROBE_CYC    = 5,
  parameter int HOLD_CYC      = 1,
  parameter int RECOV_CYC     = 1,
  parameter int CYCLE_MIN_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_bc_lo_n,
  output logic              mem_bc_hi_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LANE_W    = DATA_W / 2;
  localparam int ACTIVE    = SETUP_CYC + STROBE_CYC + HOLD_CYC;
  localparam int RECOV_EFF = max_int(RECOV_CYC, CYCLE_MIN_CYC - ACTIVE);
  localparam int MAX_LEN   = max_int(max_int(SETUP_CYC, STROBE_CYC),
                                     max_int(HOLD_CYC, RECOV_EFF));
  localparam int CNT_W     = max_int(1, $clog2(MAX_LEN + 1));

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  phase_e           phase, phase_nxt;
  logic             start, last, load;
  logic [CNT_W-1:0] load_val;

  assign req_ready = rst_i_n && (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  sram_phase_fsm #(
    .CNT_W(CNT_W), .SETUP_LEN(SETUP_CYC), .STROBE_LEN(STROBE_CYC),
    .HOLD_LEN(HOLD_CYC), .RECOV_LEN(RECOV_EFF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .start(start), .last(last),
    .phase(phase), .phase_nxt(phase_nxt), .load(load), .load_val(load_val)
  );

  sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .load(load), .load_val(load_val), .last(last)
  );

  // request capture, clock-enabled by acceptance
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q, mask_nxt;
  logic              write_q, write_nxt;

  assign mask_nxt  = start ? req_mask  : mask_q;
  assign write_nxt = start ? req_write : write_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      write_q <= req_write;
    end
  end

  // registered pin controls, decoded from the next phase
  logic       sel_nxt, strobe_nxt;
  logic [1:0] bc_n_nxt, bc_n_q;
  logic       sel_q, we_n_q, oe_n_q, dq_oe_q;

  assign sel_nxt    = (phase_nxt == PH_SETUP) || (phase_nxt == PH_STROBE) ||
                      (phase_nxt == PH_HOLD);
  assign strobe_nxt = (phase_nxt == PH_STROBE);

  logic [DATA_W-1:0] rd_nxt;
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    assign bc_n_nxt[ln] = ~(sel_nxt & mask_nxt[ln]);
    assign rd_nxt[ln*LANE_W +: LANE_W] =
      mask_q[ln] ? mem_dq_i[ln*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sel_q   <= 1'b0;
      bc_n_q  <= 2'b11;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      sel_q   <= sel_nxt;
      bc_n_q  <= bc_n_nxt;
      we_n_q  <= ~(strobe_nxt & write_nxt);
      oe_n_q  <= ~(strobe_nxt & ~write_nxt);
      dq_oe_q <= strobe_nxt & write_nxt;
    end
  end

  // read capture and completion pulse
  logic              capture;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  assign capture = (phase == PH_STROBE) && last;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= capture;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                  rdata_q <= '0;
    else if (capture && !write_q)  rdata_q <= rd_nxt;
    else if (capture)              rdata_q <= '0;
  end

  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_cs_n    = ~sel_q;
  assign mem_cs      = sel_q;
  assign mem_bc_lo_n = bc_n_q[0];
  assign mem_bc_hi_n = bc_n_q[1];
  assign mem_we_n    = we_n_q;
  assign mem_oe_n    = oe_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe   = dq_oe_q;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_bc_lo_n,
  input logic              mem_bc_hi_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  logic sel;
  assign sel = !mem_cs_n && mem_cs;

  AST_WE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> sel);  // R4
  AST_WE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(sel));  // R4
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);  // R4
  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));  // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));  // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(mem_addr));  // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R7
  AST_READY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sel && mem_we_n && mem_oe_n && !mem_dq_oe));  // R8
  AST_LANE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_bc_lo_n || !mem_bc_hi_n) |-> sel);  // R3
endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
  .mem_bc_lo_n(mem_bc_lo_n), .mem_bc_hi_n(mem_bc_hi_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int S = 1, W = 5, H = 1, R = 1, CMIN = 6;
  localparam int T = S + W + H + R;
  localparam int S2 = 1, W2 = 2, H2 = 1, R2 = 1, CMIN2 = 9;
  localparam int T2 = CMIN2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write, rsp_done;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [1:0]    req_mask;
  logic mem_cs_n, mem_cs, mem_bc_lo_n, mem_bc_hi_n, mem_we_n, mem_oe_n, mem_dq_oe;

  sram_async_ctl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .STROBE_CYC(W),
    .HOLD_CYC(H), .RECOV_CYC(R), .CYCLE_MIN_CYC(CMIN)) u_sram_async_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_bc_lo_n(mem_bc_lo_n), .mem_bc_hi_n(mem_bc_hi_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  // second instance: long cycle minimum stretches recovery
  logic          v2, rdy2, done2;
  logic [DW-1:0] rd2, dqo2;
  logic [AW-1:0] a2;
  logic csn2, cs2, bl2, bh2, wen2, oen2, dqoe2;
  sram_async_ctl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S2), .STROBE_CYC(W2),
    .HOLD_CYC(H2), .RECOV_CYC(R2), .CYCLE_MIN_CYC(CMIN2)) u_sram_async_ctl_str (
    .clk(clk), .rst_n(rst_n), .req_valid(v2), .req_ready(rdy2),
    .req_write(1'b0), .req_addr(4'h3), .req_wdata(16'h0),
    .req_mask(2'b11), .rsp_done(done2), .rsp_rdata(rd2),
    .mem_addr(a2), .mem_cs_n(csn2), .mem_cs(cs2),
    .mem_bc_lo_n(bl2), .mem_bc_hi_n(bh2), .mem_we_n(wen2),
    .mem_oe_n(oen2), .mem_dq_o(dqo2), .mem_dq_oe(dqoe2),
    .mem_dq_i(16'h1234));

  // memory model: lanes not driven read as A5
  logic [DW-1:0] ram [1<<AW];
  logic [DW-1:0] shadow [1<<AW];
  logic chip_on;
  assign chip_on = !mem_cs_n && mem_cs;
  assign mem_dq_i[7:0]  = (chip_on && !mem_bc_lo_n && !mem_oe_n && mem_we_n) ?
                          ram[mem_addr][7:0]  : 8'hA5;
  assign mem_dq_i[15:8] = (chip_on && !mem_bc_hi_n && !mem_oe_n && mem_we_n) ?
                          ram[mem_addr][15:8] : 8'hA5;

  always @(negedge clk) begin
    if (chip_on && !mem_we_n && mem_dq_oe) begin
      if (!mem_bc_lo_n) ram[mem_addr][7:0]  <= mem_dq_o[7:0];
      if (!mem_bc_hi_n) ram[mem_addr][15:8] <= mem_dq_o[15:8];
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [1:0] m);
    int selc = 0, loc = 0, hic = 0, wec = 0, oec = 0, dqc = 0, dqbad = 0;
    int abad = 0, firstwe = -1, donek = -1, donec = 0, readyk = -1;
    logic [DW-1:0] rd = '0, expd;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      end
      if (chip_on) begin
        selc++;
        if (mem_addr != a) abad++;
      end
      if (!mem_bc_lo_n) loc++;
      if (!mem_bc_hi_n) hic++;
      if (!mem_we_n) begin
        wec++;
        if (firstwe < 0) firstwe = k;
      end
      if (!mem_oe_n) oec++;
      if (mem_dq_oe) begin
        dqc++;
        if (mem_dq_o != d) dqbad++;
      end
      if (rsp_done) begin
        donec++; donek = k; rd = rsp_rdata;
      end
      if (req_ready) begin
        readyk = k; break;
      end
    end
    chk(selc == S + W + H, "R2", "select clocks", selc, S + W + H);
    chk(loc == (m[0] ? S + W + H : 0), "R3", "low lane clocks", loc, m[0] ? S + W + H : 0);
    chk(hic == (m[1] ? S + W + H : 0), "R3", "high lane clocks", hic, m[1] ? S + W + H : 0);
    chk(donek == S + W && donec == 1, "R7", "done clock", donek, S + W);
    chk(readyk == T, "R8", "access length", readyk, T);
    chk(abad == 0, "R9", "address changes", abad, 0);
    if (wr) begin
      chk(wec == W && firstwe == S, "R4", "strobe width/start", wec * 16 + firstwe, W * 16 + S);
      chk(oec == 0, "R4", "oe during write", oec, 0);
      chk(dqc == W && dqbad == 0, "R5", "pad drive", dqc * 16 + dqbad, W * 16);
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
      if (m == 2'b00) chk(ram[a] == shadow[a], "R10", "empty-mask write", int'(ram[a]), int'(shadow[a]));
    end else begin
      expd = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
      chk(oec == W && wec == 0, "R6", "read strobe", oec * 16 + wec, W * 16);
      chk(dqc == 0, "R5", "pad drive in read", dqc, 0);
      chk(rd == expd, (m == 2'b00) ? "R10" : "R6", "read data", int'(rd), int'(expd));
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      chk(1'b0, "WDG", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k2, dk2, rk2;
    logic [DW-1:0] r2;
    for (int i = 0; i < (1 << AW); i++) begin
      ram[i] = '0; shadow[i] = '0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_mask = 2'b00; v2 = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && !mem_cs && mem_bc_lo_n && mem_bc_hi_n && mem_we_n && mem_oe_n
        && !mem_dq_oe, "R1", "pins in reset", 0, 0);
    chk(!req_ready, "R1", "ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1", "ready one edge after release", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready, "R1", "ready two edges after release", int'(req_ready), 1);
    chk(mem_cs_n && !mem_cs && mem_bc_lo_n && mem_bc_hi_n && mem_we_n && mem_oe_n
        && !mem_dq_oe, "R1", "pins idle after release", 0, 0);

    for (int a = 0; a < (1 << AW); a++)
      txn(1'b1, AW'(a), DW'(a * 16'h0101) ^ 16'h3C5A, 2'b11);
    for (int a = 0; a < (1 << AW); a++)
      for (int m = 0; m < 4; m++) txn(1'b0, AW'(a), '0, 2'(m));
    for (int a = 0; a < (1 << AW); a++) begin
      if (a % 2 == 0) txn(1'b1, AW'(a), ~DW'(a * 16'h1111), 2'b01);
      if (a % 3 == 0) txn(1'b1, AW'(a), DW'(a * 16'h0F0F) + 16'h8001, 2'b10);
    end
    txn(1'b1, 4'd5, 16'hFFFF, 2'b00);
    for (int a = 0; a < (1 << AW); a++) txn(1'b0, AW'(a), '0, 2'b11);

    // stretched recovery on the second instance: R8, R7
    @(negedge clk);
    v2 = 1'b1;
    @(posedge clk);
    dk2 = -1; rk2 = -1; r2 = '0;
    for (k2 = 0; k2 < 100; k2++) begin
      @(negedge clk);
      if (k2 == 0) v2 = 1'b0;
      if (done2) begin dk2 = k2; r2 = rd2; end
      if (rdy2) begin rk2 = k2; break; end
    end
    chk(rk2 == T2, "R8", "stretched access length", rk2, T2);
    chk(dk2 == S2 + W2, "R7", "stretched done clock", dk2, S2 + W2);
    chk(r2 == 16'h1234, "R6", "stretched read data", int'(r2), 16'h1234);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule